// File: doc/BRIEF.md
# Write-Status Read Path

This block is the read side of a byte-wide nonvolatile memory that programs itself after a write. A host read is open while chip-enable and output-enable are both low. During an open read the block drives a data word and raises a drive-enable flag. When either strobe is high it drops the drive flag and holds the data lines at zero. The strobes are sampled on the system clock, and every output is registered, so the bus follows the inputs one clock later.

While the companion page-load logic reports programming in progress (`busy`), the read word does not come from the array. It carries status in band:
- The top bit is the inverse of bit 7 of the last byte written.
- The next bit is a toggle flag that changes once per read access.
- The low six bits, which the status layout leaves reserved, carry the low bits of the last written byte.

Once `busy` falls, reads return array data again and the toggle flag stops changing. A host can then poll either bit to detect the end of the write cycle.

Top module: `wsr_read_path`

## Requirements
- R1: `bus_drive` is 1 in the clock cycle after an edge at which `ce_n` and `oe_n` were both sampled low. It is 0 in the cycle after an edge at which either was sampled high.
- R2: Whenever `bus_drive` is 0, `bus_dout` is all zeros.
- R3: During an open read with `busy` sampled 0, `bus_dout` equals the `arr_data` sampled at the same edge, bit for bit.
- R4: During an open read with `busy` sampled 1, `bus_dout[7]` is the complement of `last_data[7]` sampled at the same edge. This holds for every address read.
- R5: During an open read with `busy` sampled 1, `bus_dout[6]` holds the toggle flag. Two busy read accesses in a row show opposite values.
- R6: During an open read with `busy` sampled 1, `bus_dout[5:0]` equals `last_data[5:0]`.
- R7: The toggle flag advances only when a read access starts with `busy` sampled 1. Accesses that start while not busy leave it unchanged, so the next busy access shows the opposite of the last busy one.
- R8: A read access starts at the first edge where both strobes are low after an edge where either was high. The toggle value stays constant for as long as the strobes stay low. Raising and lowering `ce_n` alone, with `oe_n` held low, starts a new access.
- R9: While `rst_n` is sampled low, `bus_drive` is 0 and `bus_dout` is zero, whatever the strobes do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| busy | input | 1 | Internal programming in progress |
| last_data | input | 8 | Last byte written, from the page-load logic |
| arr_data | input | 8 | Array word at the current read address |
| bus_dout | output | 8 | Read data toward the bus driver |
| bus_drive | output | 1 | Bus driver enable |

## Verification
Two functions can meet in a single cycle: the start of a read access and the end of programming. In that case the new access must return true data and must not advance the toggle flag. The bench provokes this by lowering both strobes at the same edge where `busy` is first sampled low, after a series of busy reads. It judges the result twice. That read must show the array word. The next busy read must then show a toggle value opposite to the last busy read before the collision.

// File: rtl/wsr_pkg.sv
// Package: shared definitions for the write-status read path.
// Assumes: a byte-or-wider data path; bit positions are fixed relative to the MSB.
package wsr_pkg;

    // Source that feeds the registered read word
    typedef enum logic [1:0] {
        SRC_IDLE   = 2'd0,
        SRC_ARRAY  = 2'd1,
        SRC_STATUS = 2'd2
    } wsr_src_e;

endpackage

// File: rtl/wsr_access_detect.sv
// Module: wsr_access_detect
// Samples the active-low strobes and reports an open read access and its
// first cycle (the falling edge of the combined enable).
// Assumes: strobes are already synchronous to clk.
module wsr_access_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n,
    input  logic oe_n,
    output logic acc_now,
    output logic acc_start
);

    logic acc_q;

    // Combined enable as seen at this edge
    always_comb acc_now = ~ce_n & ~oe_n;

    // Previous-cycle enable, used for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) acc_q <= 1'b0;
        else        acc_q <= acc_now;
    end

    // Start pulse: enable present now, absent at the previous edge
    always_comb acc_start = acc_now & ~acc_q;

    // R8
    start_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_start |=> !acc_start);

endmodule

// File: rtl/wsr_toggle_reg.sv
// Module: wsr_toggle_reg
// Holds the toggle flag shown on the status word; flips once per advance.
// Assumes: adv is a single-cycle pulse per busy read access.
module wsr_toggle_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic adv,
    output logic tog_nxt
);

    logic tog_q;

    // Value that the current access will display
    always_comb tog_nxt = tog_q ^ adv;

    // Flag storage
    always_ff @(posedge clk) begin
        if (!rst_n) tog_q <= 1'b0;
        else        tog_q <= tog_nxt;
    end

    // R5
    toggle_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adv |=> (tog_q != $past(tog_q)));

    // R7
    toggle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(tog_q));

endmodule

// File: rtl/wsr_status_merge.sv
// Module: wsr_status_merge
// Builds the next read word from the selected source: zero when idle,
// array data, or the status word (inverted poll bit, toggle bit, and
// the low bits of the last written byte in the reserved positions).
// Assumes: DATA_W >= 2.
module wsr_status_merge
    import wsr_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  wsr_src_e           sel,
    input  logic [DATA_W-1:0]  arr_data,
    input  logic [DATA_W-1:0]  last_data,
    input  logic               tog,
    output logic [DATA_W-1:0]  word
);

    localparam int POLL_BIT = DATA_W - 1;
    localparam int TOG_BIT  = DATA_W - 2;

    // Per-bit selection; status bits differ only in their status value
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        logic stat_b;
        if (i == POLL_BIT) begin : g_poll
            assign stat_b = ~last_data[i];
        end else if (i == TOG_BIT) begin : g_tog
            assign stat_b = tog;
        end else begin : g_rsv
            assign stat_b = last_data[i];
        end

        // Source multiplexer for this bit
        always_comb begin
            unique case (sel)
                SRC_ARRAY:  word[i] = arr_data[i];
                SRC_STATUS: word[i] = stat_b;
                default:    word[i] = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/wsr_read_path.sv
// Module: wsr_read_path (top)
// Read side of a self-programming byte memory. Drives registered read data
// while both strobes are low; during programming the word carries status.
// Assumes: busy, last_data come from the page-load logic; arr_data is the
// array word for the presented address, valid in the same cycle.
module wsr_read_path
    import wsr_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              busy,
    input  logic [DATA_W-1:0] last_data,
    input  logic [DATA_W-1:0] arr_data,
    output logic [DATA_W-1:0] bus_dout,
    output logic              bus_drive
);

    localparam int POLL_BIT = DATA_W - 1;

    logic              acc_now;
    logic              acc_start;
    logic              tog_nxt;
    wsr_src_e          src;
    logic [DATA_W-1:0] word_nxt;
    logic [DATA_W-1:0] dout_q;
    logic              drive_q;

    wsr_access_detect u_detect (
        .clk       (clk),
        .rst_n     (rst_n),
        .ce_n      (ce_n),
        .oe_n      (oe_n),
        .acc_now   (acc_now),
        .acc_start (acc_start)
    );

    wsr_toggle_reg u_toggle (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv     (acc_start & busy),
        .tog_nxt (tog_nxt)
    );

    // Pick the source of the next word
    always_comb begin
        if (!acc_now)  src = SRC_IDLE;
        else if (busy) src = SRC_STATUS;
        else           src = SRC_ARRAY;
    end

    wsr_status_merge #(.DATA_W(DATA_W)) u_merge (
        .sel       (src),
        .arr_data  (arr_data),
        .last_data (last_data),
        .tog       (tog_nxt),
        .word      (word_nxt)
    );

    // Output registers toward the bus driver
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout_q  <= '0;
            drive_q <= 1'b0;
        end else begin
            dout_q  <= word_nxt;
            drive_q <= acc_now;
        end
    end

    assign bus_dout  = dout_q;
    assign bus_drive = drive_q;

    // R1
    drive_follows_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !oe_n) |=> bus_drive);

    // R2
    release_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_n || oe_n) |=> (!bus_drive && bus_dout == '0));

    // R3
    true_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !oe_n && !busy) |=> (bus_dout == $past(arr_data)));

    // R4
    poll_invert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !oe_n && busy) |=> (bus_dout[POLL_BIT] == ~$past(last_data[POLL_BIT])));

endmodule

// File: tb/wsr_read_path_bench.sv
// Scoreboard bench: the driver applies one input set per cycle on the falling
// clock edge and queues the expected result; the monitor checks it shortly
// after the next rising edge.
module wsr_read_path_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ce_n = 1'b1;
    logic       oe_n = 1'b1;
    logic       busy = 1'b0;
    logic [7:0] last_data = 8'h00;
    logic [7:0] arr_data = 8'h00;
    logic [7:0] bus_dout;
    logic       bus_drive;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // toggle modes: 0 none, 1 record, 2 must differ then record, 3 must equal
    typedef struct {
        logic       en;
        logic [7:0] data;
        logic [7:0] mask;
        int         tmode;
        string      tag;
    } exp_t;

    exp_t exp_q[$];
    logic tref;

    always #4 clk = ~clk;

    wsr_read_path u_wsr_read_path (
        .clk       (clk),
        .rst_n     (rst_n),
        .ce_n      (ce_n),
        .oe_n      (oe_n),
        .busy      (busy),
        .last_data (last_data),
        .arr_data  (arr_data),
        .bus_dout  (bus_dout),
        .bus_drive (bus_drive)
    );

    task automatic rd(input logic c, input logic o, input logic b,
                      input logic [7:0] ld, input logic [7:0] ad,
                      input int tm, input string tag);
        exp_t e;
        @(negedge clk);
        ce_n = c; oe_n = o; busy = b; last_data = ld; arr_data = ad;
        e.en = !c && !o;
        e.tmode = tm;
        e.tag = tag;
        if (!e.en) begin
            e.data = 8'h00; e.mask = 8'hFF;
        end else if (b) begin
            e.data = {~ld[7], 1'b0, ld[5:0]}; e.mask = 8'hBF;
        end else begin
            e.data = ad; e.mask = 8'hFF;
        end
        exp_q.push_back(e);
    endtask

    // Monitor: compares one queued item per cycle
    initial begin
        forever begin
            @(posedge clk);
            #3;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                checks++;
                if (bus_drive !== e.en || ((bus_dout ^ e.data) & e.mask) !== 8'h00) begin
                    fails++;
                    $display("FAIL %s: drive=%b dout=%h expected drive=%b dout=%h mask=%h",
                             e.tag, bus_drive, bus_dout, e.en, e.data, e.mask);
                end
                if (e.tmode == 1) begin
                    tref = bus_dout[6];
                end else if (e.tmode == 2) begin
                    checks++;
                    if (bus_dout[6] === tref) begin
                        fails++;
                        $display("FAIL %s: toggle=%b expected %b", e.tag, bus_dout[6], ~tref);
                    end
                    tref = bus_dout[6];
                end else if (e.tmode == 3) begin
                    checks++;
                    if (bus_dout[6] !== tref) begin
                        fails++;
                        $display("FAIL %s: toggle=%b expected %b", e.tag, bus_dout[6], tref);
                    end
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    // Driver sequence
    initial begin
        // R9: reset dominates open strobes
        ce_n = 1'b0; oe_n = 1'b0; busy = 1'b1; last_data = 8'h00;
        repeat (3) @(negedge clk);
        checks++;
        if (bus_drive !== 1'b0 || bus_dout !== 8'h00) begin
            fails++;
            $display("FAIL R9: drive=%b dout=%h expected drive=0 dout=00", bus_drive, bus_dout);
        end
        ce_n = 1'b1; oe_n = 1'b1; busy = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;

        rd(1, 1, 0, 8'h00, 8'h00, 0, "R2");
        // R3: array data tracks while the read stays open
        rd(0, 0, 0, 8'h00, 8'hA5, 0, "R3");
        rd(0, 0, 0, 8'h00, 8'h3C, 0, "R3");
        rd(0, 0, 0, 8'h00, 8'hFF, 0, "R3");
        // R1/R2: either strobe high releases
        rd(1, 0, 0, 8'h00, 8'h77, 0, "R1");
        rd(0, 1, 0, 8'h00, 8'h77, 0, "R2");
        // R4/R6: busy read, record toggle; held read keeps it (R8)
        rd(0, 0, 1, 8'h5A, 8'h11, 1, "R4");
        rd(0, 0, 1, 8'h5A, 8'h22, 3, "R8");
        rd(0, 0, 1, 8'h5A, 8'h33, 3, "R8");
        rd(1, 1, 1, 8'h5A, 8'h00, 0, "R2");
        // R5: new busy access flips the toggle
        rd(0, 0, 1, 8'hC3, 8'h44, 2, "R5");
        // R8: ce_n pulse alone starts a new access
        rd(1, 0, 1, 8'hC3, 8'h44, 0, "R1");
        rd(0, 0, 1, 8'hC3, 8'h44, 2, "R8");
        rd(1, 1, 1, 8'h2A, 8'h00, 0, "R2");
        // R6: reserved bits show last data low bits, bit 7 inverted from 0
        rd(0, 0, 1, 8'h2A, 8'h55, 2, "R6");
        // R7: busy ends during an open read -> true data at once
        rd(0, 0, 0, 8'h2A, 8'h96, 0, "R7");
        rd(1, 1, 0, 8'h2A, 8'h00, 0, "R2");
        rd(0, 0, 0, 8'h2A, 8'h81, 0, "R7");
        rd(1, 1, 0, 8'h2A, 8'h00, 0, "R2");
        rd(0, 0, 0, 8'h2A, 8'h18, 0, "R7");
        rd(1, 1, 0, 8'h2A, 8'h00, 0, "R2");
        // R7: idle accesses did not advance the flag
        rd(0, 0, 1, 8'hE7, 8'h00, 2, "R7");
        rd(1, 1, 1, 8'hE7, 8'h00, 0, "R2");
        // Collision: access starts in the cycle busy drops
        rd(0, 0, 0, 8'hE7, 8'h5C, 0, "R7");
        rd(1, 1, 1, 8'hE7, 8'h00, 0, "R2");
        rd(0, 0, 1, 8'hE7, 8'h09, 2, "R5");
        rd(1, 1, 0, 8'h00, 8'h00, 0, "R2");
        repeat (3) @(negedge clk);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule